// File: doc/BRIEF.md
# Length-Framed Event Record Packer

This block collects the samples of one event record from a single data stream and writes the whole record into a 64-bit data FIFO write port. The record starts with a header word that names the event and the stream it came from. Once the last word of the record is in the data FIFO, the block writes the record's total word count, header included, to a separate count FIFO. A reader on the far side first pops a count and then pops exactly that many data words. It never has to search the data for marker patterns.

Incoming words are held in an internal staging store until the record is complete. Only then is the record written out, and only if the data FIFO has room for all of it and the count FIFO is not full. A record that cannot be written in full is thrown away entirely, so the framing downstream stays aligned. There are two saturating counters. One counts records lost because the staging store overflowed. The other counts records lost because the output FIFOs had too little space.

Top module: `evf_framer`

## Requirements
- R1: The first data FIFO write of each committed record is a header word. Bits 63:48 hold the event ID and bits 47:40 hold the stream ID, both captured with the record's first accepted word. Bits 39:0 are zero.
- R2: After the header, the payload words are written in the order they arrived, one per clock, with no gap.
- R3: In the clock right after the last data write of a record, the count FIFO is written once with the payload word count plus one.
- R4: `s_stream_id_i` and `s_event_id_i` are read only on the first accepted word of a record. Their values on later words of the same record have no effect.
- R5: When the last word is accepted, the record is committed only if `dfree_i` is at least the payload length plus one and `cfull_i` is low. Otherwise nothing of the record is written and `drop_cnt_o` increments.
- R6: A record of up to DEPTH payload words is accepted. A longer record is discarded whole, with no FIFO write, and `ovf_cnt_o` increments.
- R7: `s_ready_o` is low from the clock after the last word is accepted until the count write, inclusive. It is high again in the clock after the count write. A discarded record does not drop `s_ready_o`.
- R8: Both counters saturate at 2^CNT_W-1.
- R9: Reset clears both counters and any partly staged record. After reset `s_ready_o` is high and no FIFO write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Input word valid |
| s_ready_o | output | 1 | Block can accept a word |
| s_data_i | input | 64 | Input sample word |
| s_last_i | input | 1 | Word is the last of its record |
| s_stream_id_i | input | 8 | Stream identifier, read on first word |
| s_event_id_i | input | 16 | Event identifier, read on first word |
| dwr_en_o | output | 1 | Data FIFO write enable |
| dwr_data_o | output | 64 | Data FIFO write word |
| dfree_i | input | FREE_W | Free slots in the data FIFO |
| cwr_en_o | output | 1 | Count FIFO write enable |
| cwr_data_o | output | $clog2(DEPTH+2) | Record word count, header included |
| cfull_i | input | 1 | Count FIFO full |
| drop_cnt_o | output | CNT_W | Records discarded for lack of space |
| ovf_cnt_o | output | CNT_W | Records discarded for staging overflow |

## Verification
The bench sends a record that fills the staging store exactly and a record one word longer. A packer with an off-by-one limit either drops the legal record or writes a truncated one. It offers exactly length-plus-one free slots and also one slot fewer, and it raises the count-full flag alone. A faulty space check would then either leave a partial record in the data FIFO or refuse a record that fits. The ID inputs carry wrong values on every word after the first, which exposes a header built from the last word's IDs. A reset in the middle of a record, followed by a short record, shows whether stale staged words leak into the next commit.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int DATA_W = 64;
  localparam int EV_W   = 16;
  localparam int ST_W   = 8;

  typedef enum logic [1:0] {ST_COLLECT, ST_DATA, ST_COUNT} evf_state_e;

  function automatic logic [DATA_W-1:0] evf_header(logic [EV_W-1:0] ev, logic [ST_W-1:0] st);
    return {ev, st, {(DATA_W-EV_W-ST_W){1'b0}}};
  endfunction
endpackage

// File: rtl/evf_stage_buf.sv
module evf_stage_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          clear_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [FW-1:0] fill_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  assign full_o  = (fill_o == FW'(DEPTH));
  assign rdata_o = mem[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_i && !full_o) mem[fill_o[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_o <= '0;
      ovf_o  <= 1'b0;
    end else if (clear_i) begin
      fill_o <= '0;
      ovf_o  <= 1'b0;
    end else if (wr_i) begin
      if (full_o) ovf_o  <= 1'b1;
      else        fill_o <= fill_o + FW'(1);
    end
  end
endmodule

// File: rtl/evf_commit_ctrl.sv
module evf_commit_ctrl
  import evf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CL_W = $clog2(DEPTH+2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            last_i,
  input  logic            word_ovf_i,
  input  logic            space_ok_i,
  input  logic [CL_W-1:0] need_i,
  output evf_state_e      state_o,
  output logic [CL_W-1:0] idx_o,
  output logic [CL_W-1:0] len_o,
  output logic            clear_o,
  output logic            drop_o,
  output logic            ovf_o
);
  logic rec_end;
  assign rec_end = accept_i && last_i;
  assign ovf_o   = rec_end && word_ovf_i;
  assign drop_o  = rec_end && !word_ovf_i && !space_ok_i;
  assign clear_o = (state_o == ST_COUNT) || ovf_o || drop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_COLLECT;
      idx_o   <= '0;
      len_o   <= '0;
    end else begin
      unique case (state_o)
        ST_COLLECT: if (rec_end && !word_ovf_i && space_ok_i) begin
          len_o   <= need_i;
          idx_o   <= '0;
          state_o <= ST_DATA;
        end
        ST_DATA: begin
          idx_o <= idx_o + CL_W'(1);
          if (idx_o == len_o - CL_W'(1)) state_o <= ST_COUNT;
        end
        ST_COUNT: state_o <= ST_COLLECT;
        default:  state_o <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/evf_sat_cnt.sv
module evf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (inc_i && cnt_o != '1)    cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/evf_framer.sv
module evf_framer
  import evf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int FREE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        s_valid_i,
  output logic                        s_ready_o,
  input  logic [63:0]                 s_data_i,
  input  logic                        s_last_i,
  input  logic [7:0]                  s_stream_id_i,
  input  logic [15:0]                 s_event_id_i,
  output logic                        dwr_en_o,
  output logic [63:0]                 dwr_data_o,
  input  logic [FREE_W-1:0]           dfree_i,
  output logic                        cwr_en_o,
  output logic [$clog2(DEPTH+2)-1:0]  cwr_data_o,
  input  logic                        cfull_i,
  output logic [CNT_W-1:0]            drop_cnt_o,
  output logic [CNT_W-1:0]            ovf_cnt_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int FW   = $clog2(DEPTH+1);
  localparam int CL_W = $clog2(DEPTH+2);

  evf_state_e       state;
  logic [CL_W-1:0]  idx, len, need;
  logic [FW-1:0]    fill;
  logic             full, buf_ovf, clear, drop_p, ovf_p, accept, space_ok;
  logic [63:0]      rdata;
  logic [EV_W-1:0]  ev_q;
  logic [ST_W-1:0]  st_q;

  assign s_ready_o = (state == ST_COLLECT);
  assign accept    = s_valid_i && s_ready_o;
  // header plus this word plus those already staged
  assign need      = CL_W'(fill) + CL_W'(2);
  assign space_ok  = (32'(dfree_i) >= 32'(need)) && !cfull_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
      st_q <= '0;
    end else if (accept && fill == '0 && !buf_ovf) begin
      ev_q <= s_event_id_i;
      st_q <= s_stream_id_i;
    end
  end

  evf_stage_buf #(.DEPTH(DEPTH), .W(64)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (accept),
    .wdata_i   (s_data_i),
    .clear_i   (clear),
    .rd_addr_i (AW'(idx - CL_W'(1))),
    .fill_o    (fill),
    .full_o    (full),
    .ovf_o     (buf_ovf),
    .rdata_o   (rdata)
  );

  evf_commit_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .last_i     (s_last_i),
    .word_ovf_i (buf_ovf || full),
    .space_ok_i (space_ok),
    .need_i     (need),
    .state_o    (state),
    .idx_o      (idx),
    .len_o      (len),
    .clear_o    (clear),
    .drop_o     (drop_p),
    .ovf_o      (ovf_p)
  );

  assign dwr_en_o   = (state == ST_DATA);
  assign dwr_data_o = (idx == '0) ? evf_header(ev_q, st_q) : rdata;
  assign cwr_en_o   = (state == ST_COUNT);
  assign cwr_data_o = len;

  evf_sat_cnt #(.W(CNT_W)) u_drop_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(drop_p), .cnt_o(drop_cnt_o)
  );
  evf_sat_cnt #(.W(CNT_W)) u_ovf_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ovf_p), .cnt_o(ovf_cnt_o)
  );
endmodule

// File: rtl/evf_framer_chk.sv
module evf_framer_chk #(
  parameter int DEPTH  = 256,
  parameter int FREE_W = 16,
  parameter int CNT_W  = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       s_ready_o,
  input logic                       dwr_en_o,
  input logic [63:0]                dwr_data_o,
  input logic [FREE_W-1:0]          dfree_i,
  input logic                       cwr_en_o,
  input logic [$clog2(DEPTH+2)-1:0] cwr_data_o,
  input logic [CNT_W-1:0]           drop_cnt_o,
  input logic [CNT_W-1:0]           ovf_cnt_o
);
  // R7
  ready_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr_en_o || cwr_en_o) |-> !s_ready_o);
  // R7
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr_en_o |=> s_ready_o);
  // R3
  cnt_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr_en_o |-> ($past(dwr_en_o) && !dwr_en_o));
  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr_en_o |-> (32'(cwr_data_o) >= 2 && 32'(cwr_data_o) <= DEPTH + 1));
  // R1
  header_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr_en_o && !$past(dwr_en_o)) |-> (dwr_data_o[39:0] == 40'd0));
  // R8
  drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1)));
  // R8
  ovf_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o != $past(ovf_cnt_o)) |-> (ovf_cnt_o == $past(ovf_cnt_o) + CNT_W'(1)));
endmodule

bind evf_framer evf_framer_chk #(.DEPTH(DEPTH), .FREE_W(FREE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_ready_o  (s_ready_o),
  .dwr_en_o   (dwr_en_o),
  .dwr_data_o (dwr_data_o),
  .dfree_i    (dfree_i),
  .cwr_en_o   (cwr_en_o),
  .cwr_data_o (cwr_data_o),
  .drop_cnt_o (drop_cnt_o),
  .ovf_cnt_o  (ovf_cnt_o)
);

// File: tb/sim_evf_framer.sv
`timescale 1ns/1ps
module sim_evf_framer;
  localparam int DEPTH  = 8;
  localparam int FREE_W = 8;
  localparam int CNT_W  = 2;
  localparam int CL_W   = $clog2(DEPTH+2);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, cfull = 1'b0;
  logic [63:0] s_data = '0;
  logic [7:0]  s_st = '0;
  logic [15:0] s_ev = '0;
  logic [FREE_W-1:0] dfree = '0;
  logic s_ready_o, dwr_en_o, cwr_en_o;
  logic [63:0] dwr_data_o;
  logic [CL_W-1:0] cwr_data_o;
  logic [CNT_W-1:0] drop_cnt_o, ovf_cnt_o;

  always #2 clk = ~clk;

  evf_framer #(.DEPTH(DEPTH), .FREE_W(FREE_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .s_valid_i(s_valid), .s_ready_o(s_ready_o),
    .s_data_i(s_data), .s_last_i(s_last), .s_stream_id_i(s_st), .s_event_id_i(s_ev),
    .dwr_en_o(dwr_en_o), .dwr_data_o(dwr_data_o), .dfree_i(dfree),
    .cwr_en_o(cwr_en_o), .cwr_data_o(cwr_data_o), .cfull_i(cfull),
    .drop_cnt_o(drop_cnt_o), .ovf_cnt_o(ovf_cnt_o)
  );

  int compared = 0, mismatched = 0;
  int dn = 0, cn = 0;
  logic [63:0] dcap [256];
  int ccap [64];
  int exp_drop = 0, exp_ovf = 0;
  localparam int CMAX = (1 << CNT_W) - 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // capture FIFO writes between edges; R7 ready must be low while writing
  always @(negedge clk) begin
    if (rst_ni) begin
      if (dwr_en_o) begin dcap[dn % 256] = dwr_data_o; dn++; end
      if (cwr_en_o) begin ccap[cn % 64] = int'(cwr_data_o); cn++; end
      if ((dwr_en_o || cwr_en_o) && s_ready_o) begin
        mismatched++; compared++;
        $display("FAIL R7 actual=1 expected=0 (ready during commit)");
      end
    end
  end

  function automatic logic [63:0] wd(input int rec, input int i);
    return {16'hA5C3, 8'(rec), 8'(i), 32'(rec * 100 + i)};
  endfunction

  task automatic send_rec(input int rec, input int n, input logic [7:0] st,
                          input logic [15:0] ev, input int free, input logic cf);
    dfree = FREE_W'(free);
    cfull = cf;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = wd(rec, i);
      s_last  = (i == n - 1);
      // R4: wrong IDs on every word after the first
      s_st    = (i == 0) ? st : ~st;
      s_ev    = (i == 0) ? ev : ~ev;
      while (!s_ready_o) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    repeat (n + 4) @(negedge clk);
  endtask

  // kind: 0 commit, 1 space drop, 2 overflow drop
  task automatic run_and_check(input int rec, input int n, input logic [7:0] st,
                               input logic [15:0] ev, input int free, input logic cf,
                               input int kind);
    int d0, c0;
    d0 = dn; c0 = cn;
    send_rec(rec, n, st, ev, free, cf);
    if (kind == 0) begin
      chk(dn - d0 == n + 1, "R2 data write count", dn - d0, n + 1);
      chk(dcap[d0 % 256] == {ev, st, 40'd0}, "R1/R4 header", dcap[d0 % 256], {ev, st, 40'd0});
      for (int i = 0; i < n; i++)
        chk(dcap[(d0 + 1 + i) % 256] == wd(rec, i), "R2 payload order",
            dcap[(d0 + 1 + i) % 256], wd(rec, i));
      chk(cn - c0 == 1, "R3 one count write", cn - c0, 1);
      chk(ccap[c0 % 64] == n + 1, "R3 count value", ccap[c0 % 64], n + 1);
    end else begin
      chk(dn == d0, (kind == 1) ? "R5 no data on drop" : "R6 no data on overflow", dn - d0, 0);
      chk(cn == c0, (kind == 1) ? "R5 no count on drop" : "R6 no count on overflow", cn - c0, 0);
      if (kind == 1 && exp_drop < CMAX) exp_drop++;
      if (kind == 2 && exp_ovf < CMAX) exp_ovf++;
    end
    chk(int'(drop_cnt_o) == exp_drop, "R5/R8 drop counter", drop_cnt_o, exp_drop);
    chk(int'(ovf_cnt_o) == exp_ovf, "R6/R8 overflow counter", ovf_cnt_o, exp_ovf);
    chk(s_ready_o == 1'b1, "R7 ready after record", s_ready_o, 1);
  endtask

  typedef struct packed {
    logic [4:0]  n;
    logic [7:0]  st;
    logic [15:0] ev;
    logic [7:0]  free;
    logic        cf;
    logic [1:0]  kind;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'd1, 8'h01, 16'h1234, 8'd16, 1'b0, 2'd0},  // shortest record
    '{5'd8, 8'h02, 16'hBEEF, 8'd9,  1'b0, 2'd0},  // R6 full depth, R5 exact space
    '{5'd3, 8'h03, 16'h0042, 8'd3,  1'b0, 2'd1},  // R5 one slot short
    '{5'd2, 8'h04, 16'h0043, 8'd16, 1'b1, 2'd1},  // R5 count FIFO full
    '{5'd9, 8'h05, 16'h0044, 8'd32, 1'b0, 2'd2},  // R6 one word too many
    '{5'd5, 8'hFE, 16'hC001, 8'd6,  1'b0, 2'd0}   // framing intact afterwards
  };

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(s_ready_o == 1'b1, "R9 ready after reset", s_ready_o, 1);
    chk(!dwr_en_o && !cwr_en_o, "R9 no writes after reset", {dwr_en_o, cwr_en_o}, 0);
    chk(drop_cnt_o == '0 && ovf_cnt_o == '0, "R9 counters zero", {drop_cnt_o, ovf_cnt_o}, 0);

    for (int v = 0; v < 6; v++)
      run_and_check(v, int'(VEC[v].n), VEC[v].st, VEC[v].ev, int'(VEC[v].free),
                    VEC[v].cf, int'(VEC[v].kind));

    // R8 saturation of both counters
    for (int k = 0; k < 3; k++) run_and_check(10 + k, 4, 8'h10, 16'h0100, 2, 1'b0, 1);
    for (int k = 0; k < 3; k++) run_and_check(20 + k, 10, 8'h11, 16'h0200, 64, 1'b0, 2);

    // R9 reset in the middle of a record
    begin
      int d0, c0;
      d0 = dn; c0 = cn;
      dfree = 8'd32; cfull = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        s_valid = 1'b1; s_last = 1'b0; s_data = wd(30, i);
        s_st = 8'h77; s_ev = 16'h7777;
        @(posedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0;
      rst_ni = 1'b0;
      repeat (2) @(negedge clk);
      rst_ni = 1'b1;
      exp_drop = 0; exp_ovf = 0;
      @(negedge clk);
      chk(drop_cnt_o == '0 && ovf_cnt_o == '0, "R9 counters cleared", {drop_cnt_o, ovf_cnt_o}, 0);
      chk(s_ready_o == 1'b1, "R9 ready after mid-record reset", s_ready_o, 1);
      chk(dn == d0 && cn == c0, "R9 partial record not emitted", dn - d0, 0);
      run_and_check(31, 2, 8'h21, 16'hABCD, 8, 1'b0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule